// File: doc/BRIEF.md
# DDR PHY Command Word Encoder

This block sits between a memory controller and a dedicated DDR PHY. The controller runs at half the memory clock rate, so one controller cycle carries two memory-clock command slots. Each cycle the block looks at both slots. It decides whether the pair is a write, a read or a non-data pair, and from that builds a PHY control word made of a type code, a control offset and a data offset. In the same cycle it produces the matching command/address FIFO entry, which holds a rising-edge half and a falling-edge half for each slot.

Auto-precharge never changes the type code. It is carried only in bit 0 of the falling-edge half of the slot's command/address value. A pair that mixes a read and a write is rejected: nothing is emitted for it, and a sticky error flag is raised. When no slot is valid the block issues nothing and drives the command/address outputs to a configurable idle level. It never inserts filler no-operation commands.

Top module: `phy_cmd_encoder`

## Requirements
- R1: If any valid slot holds a write (kind code 7) and no valid slot holds a read, the issued word carries type code 0x001.
- R2: If any valid slot holds a read (kind code 8) and no valid slot holds a write, the issued word carries type code 0x011.
- R3: A pair with at least one valid slot and neither a read nor a write carries type code 0x100. This covers kinds 0 to 6 (no-op, deselect, activate, precharge, precharge-all, refresh, mode-register-set) and any unused code.
- R4: A pair holding both a valid read and a valid write raises no strobe. On the next cycle the error flag is set.
- R5: The error flag stays set until the clear input is high. If a conflict and a clear arrive in the same cycle, the flag is set.
- R6: For a valid read or write slot, bit 0 of the falling-edge command/address half equals that slot's auto-precharge input, and every other bit passes through. For a non-data slot the auto-precharge input is ignored and both halves pass through unchanged.
- R7: The data offset field is zero for read and non-data words. For write words it equals the configured write data offset.
- R8: The control offset field of an issued word equals the control offset input.
- R9: The active-low control word strobe and the active-high FIFO write enable assert together, exactly one cycle after the pair is presented.
- R10: With no valid slot, both strobes stay inactive, the word fields are zero, and every command/address output bit is at the idle level (default 1).
- R11: An invalid slot inside an issued pair gets the idle level on both of its command/address halves.
- R12: While reset is asserted and until it has been released through the synchronizer, both strobes are inactive and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_vld_i | input | 2 | Valid bit for each slot (bit 0 = first memory cycle) |
| slot_kind_i | input | 2x4 | Command kind for each slot |
| slot_ap_i | input | 2 | Auto-precharge request for each slot |
| slot_ca_rise_i | input | 2xCA_W | Rising-edge command/address half for each slot |
| slot_ca_fall_i | input | 2xCA_W | Falling-edge command/address half for each slot |
| ctl_offset_i | input | CTL_OFF_W | Control offset copied into the word |
| wr_data_offset_i | input | DATA_OFF_W | Data offset used for write words |
| err_clr_i | input | 1 | Clears the sticky error flag |
| ctl_wr_n_o | output | 1 | Control word strobe, active low |
| ctl_cmd_o | output | 9 | Type code of the word |
| ctl_offset_o | output | CTL_OFF_W | Control offset field |
| ctl_data_offset_o | output | DATA_OFF_W | Data offset field |
| cmd_fifo_wren_o | output | 1 | FIFO entry write enable, active high |
| fifo_ca_rise_o | output | 2xCA_W | Rising-edge command/address half for each slot |
| fifo_ca_fall_o | output | 2xCA_W | Falling-edge command/address half for each slot |
| pair_err_o | output | 1 | Sticky read-plus-write error flag |

## Verification
The assertions check four things on every cycle: the two strobes always agree; a conflicting pair is never followed by a strobe; a read word always has a zero data offset; and an idle cycle is never followed by a strobe. They also check that the error flag cannot drop without a clear. The bench scenarios cover what needs known stimulus: the exact type codes, the auto-precharge bit placed in the falling-edge half, non-data slots left untouched, idle filling of invalid slots, the copied offsets, and the priority of a set over a clear.

// File: rtl/phy_cmd_pkg.sv
package phy_cmd_pkg;
  localparam int NSLOT = 2;
  localparam int KIND_W = 4;
  localparam int CMD_W = 9;

  localparam logic [KIND_W-1:0] KIND_NOP   = 4'd0;
  localparam logic [KIND_W-1:0] KIND_DESEL = 4'd1;
  localparam logic [KIND_W-1:0] KIND_ACT   = 4'd2;
  localparam logic [KIND_W-1:0] KIND_PRE   = 4'd3;
  localparam logic [KIND_W-1:0] KIND_PREA  = 4'd4;
  localparam logic [KIND_W-1:0] KIND_REF   = 4'd5;
  localparam logic [KIND_W-1:0] KIND_MRS   = 4'd6;
  localparam logic [KIND_W-1:0] KIND_WR    = 4'd7;
  localparam logic [KIND_W-1:0] KIND_RD    = 4'd8;

  localparam logic [CMD_W-1:0] CODE_WR = 9'h001;
  localparam logic [CMD_W-1:0] CODE_RD = 9'h011;
  localparam logic [CMD_W-1:0] CODE_ND = 9'h100;

  typedef enum logic [1:0] {PAIR_NONE, PAIR_ND, PAIR_WR, PAIR_RD} pair_class_e;
endpackage

// File: rtl/phy_cmd_rst_sync.sv
module phy_cmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/phy_cmd_classify.sv
module phy_cmd_classify
  import phy_cmd_pkg::*;
(
  input  logic [NSLOT-1:0]             vld_i,
  input  logic [NSLOT-1:0][KIND_W-1:0] kind_i,
  output pair_class_e                  cls_o,
  output logic                         conflict_o
);
  logic [NSLOT-1:0] is_wr, is_rd;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign is_wr[s] = vld_i[s] && (kind_i[s] == KIND_WR);
    assign is_rd[s] = vld_i[s] && (kind_i[s] == KIND_RD);
  end

  always_comb begin
    conflict_o = (|is_wr) && (|is_rd);
    if (vld_i == '0)     cls_o = PAIR_NONE;
    else if (|is_wr)     cls_o = PAIR_WR;
    else if (|is_rd)     cls_o = PAIR_RD;
    else                 cls_o = PAIR_ND;
  end
endmodule

// File: rtl/phy_cmd_slot_ca.sv
module phy_cmd_slot_ca
  import phy_cmd_pkg::*;
#(
  parameter int   CA_W     = 10,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic              vld_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic              ap_i,
  input  logic [CA_W-1:0]   ca_rise_i,
  input  logic [CA_W-1:0]   ca_fall_i,
  output logic [CA_W-1:0]   ca_rise_o,
  output logic [CA_W-1:0]   ca_fall_o
);
  localparam logic [CA_W-1:0] IDLE_CA = {CA_W{IDLE_LVL}};

  logic data_cmd;
  assign data_cmd = (kind_i == KIND_WR) || (kind_i == KIND_RD);

  always_comb begin
    if (!vld_i) begin
      ca_rise_o = IDLE_CA;
      ca_fall_o = IDLE_CA;
    end else if (data_cmd) begin
      ca_rise_o = ca_rise_i;
      ca_fall_o = {ca_fall_i[CA_W-1:1], ap_i};
    end else begin
      ca_rise_o = ca_rise_i;
      ca_fall_o = ca_fall_i;
    end
  end
endmodule

// File: rtl/phy_cmd_encoder.sv
module phy_cmd_encoder
  import phy_cmd_pkg::*;
#(
  parameter int   CA_W       = 10,
  parameter int   CTL_OFF_W  = 6,
  parameter int   DATA_OFF_W = 6,
  parameter logic IDLE_LVL   = 1'b1
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic [NSLOT-1:0]             slot_vld_i,
  input  logic [NSLOT-1:0][KIND_W-1:0] slot_kind_i,
  input  logic [NSLOT-1:0]             slot_ap_i,
  input  logic [NSLOT-1:0][CA_W-1:0]   slot_ca_rise_i,
  input  logic [NSLOT-1:0][CA_W-1:0]   slot_ca_fall_i,
  input  logic [CTL_OFF_W-1:0]         ctl_offset_i,
  input  logic [DATA_OFF_W-1:0]        wr_data_offset_i,
  input  logic                         err_clr_i,
  output logic                         ctl_wr_n_o,
  output logic [CMD_W-1:0]             ctl_cmd_o,
  output logic [CTL_OFF_W-1:0]         ctl_offset_o,
  output logic [DATA_OFF_W-1:0]        ctl_data_offset_o,
  output logic                         cmd_fifo_wren_o,
  output logic [NSLOT-1:0][CA_W-1:0]   fifo_ca_rise_o,
  output logic [NSLOT-1:0][CA_W-1:0]   fifo_ca_fall_o,
  output logic                         pair_err_o
);
  localparam logic [NSLOT*CA_W-1:0] IDLE_ROW = {(NSLOT*CA_W){IDLE_LVL}};

  logic rst_sync_n;
  phy_cmd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  pair_class_e cls;
  logic        conflict;
  phy_cmd_classify u_cls (
    .vld_i      (slot_vld_i),
    .kind_i     (slot_kind_i),
    .cls_o      (cls),
    .conflict_o (conflict)
  );

  logic [NSLOT-1:0][CA_W-1:0] enc_rise, enc_fall;
  for (genvar s = 0; s < NSLOT; s++) begin : g_ca
    phy_cmd_slot_ca #(.CA_W(CA_W), .IDLE_LVL(IDLE_LVL)) u_slot (
      .vld_i     (slot_vld_i[s]),
      .kind_i    (slot_kind_i[s]),
      .ap_i      (slot_ap_i[s]),
      .ca_rise_i (slot_ca_rise_i[s]),
      .ca_fall_i (slot_ca_fall_i[s]),
      .ca_rise_o (enc_rise[s]),
      .ca_fall_o (enc_fall[s])
    );
  end

  // Next-state logic
  logic                       issue;
  logic                       wren_d, err_d;
  logic [CMD_W-1:0]           cmd_d;
  logic [CTL_OFF_W-1:0]       coff_d;
  logic [DATA_OFF_W-1:0]      doff_d;
  logic [NSLOT-1:0][CA_W-1:0] rise_d, fall_d;

  always_comb begin
    issue  = (cls != PAIR_NONE) && !conflict;
    wren_d = issue;
    cmd_d  = '0;
    coff_d = '0;
    doff_d = '0;
    rise_d = IDLE_ROW;
    fall_d = IDLE_ROW;
    if (issue) begin
      coff_d = ctl_offset_i;
      rise_d = enc_rise;
      fall_d = enc_fall;
      unique case (cls)
        PAIR_WR: begin cmd_d = CODE_WR; doff_d = wr_data_offset_i; end
        PAIR_RD: cmd_d = CODE_RD;
        default: cmd_d = CODE_ND;
      endcase
    end
    if (conflict)       err_d = 1'b1;
    else if (err_clr_i) err_d = 1'b0;
    else                err_d = pair_err_o;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_fifo_wren_o   <= 1'b0;
      ctl_wr_n_o        <= 1'b1;
      pair_err_o        <= 1'b0;
      ctl_cmd_o         <= '0;
      ctl_offset_o      <= '0;
      ctl_data_offset_o <= '0;
      fifo_ca_rise_o    <= IDLE_ROW;
      fifo_ca_fall_o    <= IDLE_ROW;
    end else begin
      cmd_fifo_wren_o   <= wren_d;
      ctl_wr_n_o        <= !wren_d;
      pair_err_o        <= err_d;
      ctl_cmd_o         <= cmd_d;
      ctl_offset_o      <= coff_d;
      ctl_data_offset_o <= doff_d;
      fifo_ca_rise_o    <= rise_d;
      fifo_ca_fall_o    <= fall_d;
    end
  end

  // Assertions
  assert_strobe_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ctl_wr_n_o == !cmd_fifo_wren_o);

  assert_conflict_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    conflict |=> (!cmd_fifo_wren_o && ctl_wr_n_o && pair_err_o));

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (pair_err_o && !err_clr_i) |=> pair_err_o);

  assert_rd_zero_doff_R7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (cmd_fifo_wren_o && ctl_cmd_o == CODE_RD) |-> (ctl_data_offset_o == '0));

  assert_idle_no_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (slot_vld_i == '0) |=> (!cmd_fifo_wren_o && ctl_wr_n_o));
endmodule

// File: tb/phy_cmd_encoder_tb_top.sv
module phy_cmd_encoder_tb_top;
  import phy_cmd_pkg::*;
  localparam int CA_W = 10;
  localparam int CO_W = 6;
  localparam int DO_W = 6;
  localparam logic [CA_W-1:0] IDLE = {CA_W{1'b1}};

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]            vld;
  logic [1:0][3:0]       kind;
  logic [1:0]            ap;
  logic [1:0][CA_W-1:0]  car, caf;
  logic [CO_W-1:0]       coff;
  logic [DO_W-1:0]       doff;
  logic                  clr;
  logic                  wr_n, wren, err;
  logic [CMD_W-1:0]      cmd;
  logic [CO_W-1:0]       coff_o;
  logic [DO_W-1:0]       doff_o;
  logic [1:0][CA_W-1:0]  o_r, o_f;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phy_cmd_encoder #(.CA_W(CA_W), .CTL_OFF_W(CO_W), .DATA_OFF_W(DO_W), .IDLE_LVL(1'b1)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .slot_vld_i(vld), .slot_kind_i(kind), .slot_ap_i(ap),
    .slot_ca_rise_i(car), .slot_ca_fall_i(caf), .ctl_offset_i(coff), .wr_data_offset_i(doff),
    .err_clr_i(clr), .ctl_wr_n_o(wr_n), .ctl_cmd_o(cmd), .ctl_offset_o(coff_o),
    .ctl_data_offset_o(doff_o), .cmd_fifo_wren_o(wren), .fifo_ca_rise_o(o_r),
    .fifo_ca_fall_o(o_f), .pair_err_o(err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    vld = '0; kind = '0; ap = '0; car = '0; caf = '0; clr = 1'b0;
  endtask

  // Present a pair at a negedge; outputs are sampled one clock later at the next negedge.
  task automatic apply(input logic [1:0] v, input logic [3:0] k0, input logic [3:0] k1,
                       input logic [1:0] a, input logic [CA_W-1:0] r0, input logic [CA_W-1:0] f0,
                       input logic [CA_W-1:0] r1, input logic [CA_W-1:0] f1);
    vld = v; kind[0] = k0; kind[1] = k1; ap = a;
    car[0] = r0; caf[0] = f0; car[1] = r1; caf[1] = f1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_in(); coff = '0; doff = '0;
    repeat (3) @(negedge clk);
    vld = 2'b11; kind[0] = KIND_WR; kind[1] = KIND_NOP;
    @(negedge clk);
    chk("R12 wren in reset", wren, 0);
    chk("R12 wr_n in reset", wr_n, 1);
    chk("R12 err in reset", err, 0);
    idle_in();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 wren after release", wren, 0);
    chk("R10 idle ca", {o_r, o_f}, {IDLE, IDLE, IDLE, IDLE});
  endtask

  task automatic t_write();
    coff = 6'h15; doff = 6'h2a;
    apply(2'b11, KIND_ACT, KIND_WR, 2'b10, 10'h0f0, 10'h3c2, 10'h111, 10'h222);
    chk("R1 write code", cmd, 9'h001);
    chk("R9 wren", wren, 1);
    chk("R9 wr_n", wr_n, 0);
    chk("R7 write doff", doff_o, 6'h2a);
    chk("R8 coff", coff_o, 6'h15);
    chk("R6 wr ap fall bit0", o_f[1], 10'h223);
    chk("R6 nd slot untouched", {o_r[0], o_f[0], o_r[1]}, {10'h0f0, 10'h3c2, 10'h111});
  endtask

  task automatic t_read();
    coff = 6'h03; doff = 6'h3f;
    apply(2'b01, KIND_RD, KIND_WR, 2'b01, 10'h0aa, 10'h154, 10'h000, 10'h000);
    chk("R2 read code", cmd, 9'h011);
    chk("R7 read doff zero", doff_o, 0);
    chk("R6 rd ap set", o_f[0], 10'h155);
    chk("R11 invalid slot idle", {o_r[1], o_f[1]}, {IDLE, IDLE});
    apply(2'b10, KIND_NOP, KIND_RD, 2'b00, 10'h000, 10'h000, 10'h2cc, 10'h3ff);
    chk("R2 read in slot1", cmd, 9'h011);
    chk("R6 rd ap clear", o_f[1], 10'h3fe);
    chk("R8 coff", coff_o, 6'h03);
  endtask

  task automatic t_nondata();
    doff = 6'h11;
    apply(2'b11, KIND_REF, KIND_MRS, 2'b11, 10'h123, 10'h0a0, 10'h321, 10'h050);
    chk("R3 nd code", cmd, 9'h100);
    chk("R7 nd doff zero", doff_o, 0);
    chk("R6 ap ignored nd", {o_f[0], o_f[1]}, {10'h0a0, 10'h050});
    apply(2'b01, KIND_PREA, KIND_NOP, 2'b01, 10'h001, 10'h002, 10'h0, 10'h0);
    chk("R3 single nd code", cmd, 9'h100);
    chk("R11 invalid slot idle", {o_r[1], o_f[1]}, {IDLE, IDLE});
  endtask

  task automatic t_idle();
    apply(2'b00, KIND_WR, KIND_RD, 2'b11, 10'h0, 10'h0, 10'h0, 10'h0);
    chk("R10 no strobe", {wren, wr_n}, 2'b01);
    chk("R10 fields zero", {cmd, coff_o, doff_o}, 0);
    chk("R10 idle ca", {o_r, o_f}, {IDLE, IDLE, IDLE, IDLE});
  endtask

  task automatic t_conflict();
    apply(2'b11, KIND_RD, KIND_WR, 2'b00, 10'h1, 10'h2, 10'h3, 10'h4);
    chk("R4 no strobe", {wren, wr_n}, 2'b01);
    chk("R4 err set", err, 1);
    apply(2'b01, KIND_ACT, KIND_NOP, 2'b00, 10'h5, 10'h6, 10'h0, 10'h0);
    chk("R5 err sticky", err, 1);
    chk("R3 issue after conflict", cmd, 9'h100);
    clr = 1'b1;
    apply(2'b11, KIND_WR, KIND_RD, 2'b00, 10'h1, 10'h2, 10'h3, 10'h4);
    chk("R5 set beats clear", err, 1);
    apply(2'b00, KIND_NOP, KIND_NOP, 2'b00, 10'h0, 10'h0, 10'h0, 10'h0);
    chk("R5 clear", err, 0);
    clr = 1'b0;
  endtask

  initial begin
    t_reset();
    t_write();
    t_read();
    t_nondata();
    t_idle();
    t_conflict();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule